// File: doc/BRIEF.md
# Conservative Triangle Tile Binner

This block sorts screen-space triangles into 32x32-pixel screen tiles ahead of a tiled renderer. Each triangle arrives with three signed fixed-point vertex positions and a primitive index. The block works out every tile the triangle could touch, using its bounding box clamped to the screen in tile units. For each such tile it emits one entry carrying the tile column, the tile row and the primitive index. The test is conservative: a tile the triangle misses but its bounding box covers is still listed.

Back-facing, degenerate and fully off-screen triangles are consumed without producing entries. A triangle that falls inside a single tile is inserted in the cycle it is accepted, with no walk. Larger triangles are walked tile by tile in row-major order, one insertion per clock. The block counts the entries written into the per-frame list. When the list is full and a triangle still has tiles to insert, it requests a partial render through `flush_req` and pauses. It resumes with the remaining tiles once `flush_done` returns. `frame_start` empties the count for a new frame.

Top module: `tri_tile_binner`

## Requirements
- R1: After reset `bin_valid` and `flush_req` are low and `tri_ready` is high.
- R2: A triangle whose doubled signed area A = (x1-x0)*(y2-y0) - (x2-x0)*(y1-y0) is zero or negative is accepted and produces no entry; A > 0 is the front-facing winding.
- R3: A triangle whose bounding box lies wholly outside the screen (0..SCR_TILES_X*32-1 by 0..SCR_TILES_Y*32-1 pixels) produces no entry.
- R4: A kept triangle yields exactly one entry for each tile in its bounding box clamped to the screen, where tile column = clamped x >> 5 and tile row = clamped y >> 5; `bin_tx`, `bin_ty` and `bin_prim` carry the column, the row and the triangle's primitive index.
- R5: Entries of one triangle leave in row-major order: the column increases within a row, then the row increases.
- R6: A kept triangle covering a single tile, with the list not full, has its entry valid in the cycle after acceptance, and such triangles are accepted back to back, one per clock.
- R7: A multi-tile triangle with `bin_ready` held high emits its entries on consecutive clocks.
- R8: While `bin_valid` is high and `bin_ready` is low, the entry fields and `bin_valid` hold their values.
- R9: At most LIST_DEPTH entries are emitted between clears; `flush_req` rises only when the list holds exactly LIST_DEPTH entries and a triangle still has tiles pending, and it stays high until `flush_done`.
- R10: After `flush_done` the pending triangle's remaining tiles are emitted, with none lost or repeated.
- R11: A `frame_start` pulse empties the entry count, so LIST_DEPTH further entries fit without a flush.
- R12: `tri_ready` is low while `flush_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that empties the list count |
| tri_valid | input | 1 | Triangle offered |
| tri_ready | output | 1 | Triangle accepted when both are high |
| tri_v0x | input | COORD_W | Vertex 0 x, signed pixels |
| tri_v0y | input | COORD_W | Vertex 0 y, signed pixels |
| tri_v1x | input | COORD_W | Vertex 1 x, signed pixels |
| tri_v1y | input | COORD_W | Vertex 1 y, signed pixels |
| tri_v2x | input | COORD_W | Vertex 2 x, signed pixels |
| tri_v2y | input | COORD_W | Vertex 2 y, signed pixels |
| tri_prim | input | PRIM_W | Primitive index |
| bin_valid | output | 1 | Entry valid |
| bin_ready | input | 1 | Entry taken when both are high |
| bin_tx | output | clog2(SCR_TILES_X) | Tile column |
| bin_ty | output | clog2(SCR_TILES_Y) | Tile row |
| bin_prim | output | PRIM_W | Primitive index of the entry |
| flush_req | output | 1 | Partial render requested, list full |
| flush_done | input | 1 | Partial render finished, list emptied |

## Verification
Single-tile triangles sent back to back separate the one-cycle insertion from the walk, and the walk from a per-tile cost paid even for one tile. A 3x2-tile triangle checks the row-major walk and its rate of one entry per clock. Triangles crossing the left, top and right screen edges check the clamping, and wholly off-screen, reversed-winding and collinear triangles check that discarded work leaves no trace. Random output stalls check that entries hold still. A sequence of 16, 1 and 20 tiles against a 16-entry list makes the flush land exactly at capacity, once on a fresh triangle and once in the middle of a walk, and shows that the remaining tiles follow after the flush.

// File: rtl/tbin_pkg.sv
package tbin_pkg;

    // Walker control states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_FLUSH = 2'd2
    } walk_st_e;

endpackage

// File: rtl/tbin_setup.sv
// Triangle setup: winding, screen rejection and clamped tile range.
module tbin_setup #(
    parameter int COORD_W    = 14,
    parameter int TILE_SHIFT = 5,
    parameter int SCR_TX     = 20,
    parameter int SCR_TY     = 15,
    localparam int TX_W      = $clog2(SCR_TX),
    localparam int TY_W      = $clog2(SCR_TY)
) (
    input  logic signed [COORD_W-1:0] v0x,
    input  logic signed [COORD_W-1:0] v0y,
    input  logic signed [COORD_W-1:0] v1x,
    input  logic signed [COORD_W-1:0] v1y,
    input  logic signed [COORD_W-1:0] v2x,
    input  logic signed [COORD_W-1:0] v2y,
    output logic                      keep,
    output logic                      single,
    output logic [TX_W-1:0]           tx_lo,
    output logic [TX_W-1:0]           tx_hi,
    output logic [TY_W-1:0]           ty_lo,
    output logic [TY_W-1:0]           ty_hi
);

    localparam int DW = COORD_W + 1;
    localparam int AW = 2 * COORD_W + 3;
    localparam logic signed [COORD_W-1:0] X_LAST = COORD_W'((SCR_TX << TILE_SHIFT) - 1);
    localparam logic signed [COORD_W-1:0] Y_LAST = COORD_W'((SCR_TY << TILE_SHIFT) - 1);

    logic signed [DW-1:0] ax, ay, bx, by;
    logic signed [AW-1:0] area2;
    logic signed [COORD_W-1:0] min_x, max_x, min_y, max_y;
    logic signed [COORD_W-1:0] lo_x, hi_x, lo_y, hi_y;
    logic front, onscreen;

    function automatic logic signed [COORD_W-1:0] min3(
        input logic signed [COORD_W-1:0] a, b, c);
        logic signed [COORD_W-1:0] m;
        m = (a < b) ? a : b;
        return (c < m) ? c : m;
    endfunction

    function automatic logic signed [COORD_W-1:0] max3(
        input logic signed [COORD_W-1:0] a, b, c);
        logic signed [COORD_W-1:0] m;
        m = (a > b) ? a : b;
        return (c > m) ? c : m;
    endfunction

    always_comb begin
        ax    = DW'(v1x) - DW'(v0x);
        ay    = DW'(v1y) - DW'(v0y);
        bx    = DW'(v2x) - DW'(v0x);
        by    = DW'(v2y) - DW'(v0y);
        area2 = AW'(ax) * AW'(by) - AW'(bx) * AW'(ay);
        front = (area2 > 0);

        min_x = min3(v0x, v1x, v2x);
        max_x = max3(v0x, v1x, v2x);
        min_y = min3(v0y, v1y, v2y);
        max_y = max3(v0y, v1y, v2y);

        onscreen = !(max_x < 0 || max_y < 0 || min_x > X_LAST || min_y > Y_LAST);

        lo_x = (min_x < 0) ? '0 : min_x;
        lo_y = (min_y < 0) ? '0 : min_y;
        hi_x = (max_x > X_LAST) ? X_LAST : max_x;
        hi_y = (max_y > Y_LAST) ? Y_LAST : max_y;

        tx_lo = TX_W'($unsigned(lo_x) >> TILE_SHIFT);
        tx_hi = TX_W'($unsigned(hi_x) >> TILE_SHIFT);
        ty_lo = TY_W'($unsigned(lo_y) >> TILE_SHIFT);
        ty_hi = TY_W'($unsigned(hi_y) >> TILE_SHIFT);

        keep   = front && onscreen;
        single = (tx_lo == tx_hi) && (ty_lo == ty_hi);
    end

endmodule

// File: rtl/tbin_capacity.sv
// Entry counter for the per-frame parameter list.
module tbin_capacity #(
    parameter int LIST_DEPTH = 256,
    localparam int CW        = $clog2(LIST_DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic clr,
    output logic full
);

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr)
            count_d = '0;
        else if (inc)
            count_d = count_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else
            count_q <= count_d;
    end

    assign full = (count_q == CW'(LIST_DEPTH));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (count_q < CW'(LIST_DEPTH)));

endmodule

// File: rtl/tbin_walker.sv
// Acceptance, single-tile insertion, row-major walk, flush control and output register.
module tbin_walker
    import tbin_pkg::*;
#(
    parameter int TX_W   = 5,
    parameter int TY_W   = 4,
    parameter int PRIM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tri_valid,
    output logic              tri_ready,
    input  logic [PRIM_W-1:0] tri_prim,
    input  logic              keep,
    input  logic              single,
    input  logic [TX_W-1:0]   tx_lo,
    input  logic [TX_W-1:0]   tx_hi,
    input  logic [TY_W-1:0]   ty_lo,
    input  logic [TY_W-1:0]   ty_hi,
    input  logic              full,
    output logic              ins,
    input  logic              flush_done,
    output logic              flush_req,
    output logic              bin_valid,
    input  logic              bin_ready,
    output logic [TX_W-1:0]   bin_tx,
    output logic [TY_W-1:0]   bin_ty,
    output logic [PRIM_W-1:0] bin_prim
);

    typedef struct packed {
        walk_st_e          st;
        logic [TX_W-1:0]   cx;
        logic [TX_W-1:0]   row_x;
        logic [TX_W-1:0]   end_x;
        logic [TY_W-1:0]   cy;
        logic [TY_W-1:0]   end_y;
        logic [PRIM_W-1:0] prim;
        logic              ov;
        logic [TX_W-1:0]   otx;
        logic [TY_W-1:0]   oty;
        logic [PRIM_W-1:0] oprim;
    } walk_t;

    walk_t w_d, w_q;
    logic  can_load;
    logic  accept;

    always_comb begin
        w_d      = w_q;
        ins      = 1'b0;
        can_load = !w_q.ov || bin_ready;
        if (w_q.ov && bin_ready)
            w_d.ov = 1'b0;

        tri_ready = (w_q.st == ST_IDLE) && can_load;
        accept    = tri_valid && tri_ready;

        case (w_q.st)
            ST_IDLE: begin
                if (accept && keep) begin
                    if (single && !full) begin
                        w_d.ov    = 1'b1;
                        w_d.otx   = tx_lo;
                        w_d.oty   = ty_lo;
                        w_d.oprim = tri_prim;
                        ins       = 1'b1;
                    end else begin
                        w_d.st    = ST_WALK;
                        w_d.cx    = tx_lo;
                        w_d.row_x = tx_lo;
                        w_d.end_x = tx_hi;
                        w_d.cy    = ty_lo;
                        w_d.end_y = ty_hi;
                        w_d.prim  = tri_prim;
                    end
                end
            end
            ST_WALK: begin
                if (full) begin
                    w_d.st = ST_FLUSH;
                end else if (can_load) begin
                    w_d.ov    = 1'b1;
                    w_d.otx   = w_q.cx;
                    w_d.oty   = w_q.cy;
                    w_d.oprim = w_q.prim;
                    ins       = 1'b1;
                    if (w_q.cx == w_q.end_x) begin
                        if (w_q.cy == w_q.end_y) begin
                            w_d.st = ST_IDLE;
                        end else begin
                            w_d.cx = w_q.row_x;
                            w_d.cy = w_q.cy + TY_W'(1);
                        end
                    end else begin
                        w_d.cx = w_q.cx + TX_W'(1);
                    end
                end
            end
            ST_FLUSH: begin
                if (flush_done)
                    w_d.st = ST_WALK;
            end
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q    <= '0;
            w_q.st <= ST_IDLE;
        end else begin
            w_q <= w_d;
        end
    end

    assign flush_req = (w_q.st == ST_FLUSH);
    assign bin_valid = w_q.ov;
    assign bin_tx    = w_q.otx;
    assign bin_ty    = w_q.oty;
    assign bin_prim  = w_q.oprim;

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_valid && !bin_ready) |=> (bin_valid && $stable(bin_tx)
                                       && $stable(bin_ty) && $stable(bin_prim)));

    // R12
    no_accept_in_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !tri_ready);

    // R9
    flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_done) |=> flush_req);

    // R10
    flush_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_done) |=> !flush_req);

    // R6
    fast_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tri_valid && tri_ready && keep && single && !full) |=> bin_valid);

    // R2
    cull_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tri_valid && tri_ready && !keep && !bin_valid) |=> !bin_valid);

endmodule

// File: rtl/tri_tile_binner.sv
// Top: conservative tile binner with single-tile insertion and list capacity flush.
module tri_tile_binner #(
    parameter int COORD_W      = 14,
    parameter int PRIM_W       = 16,
    parameter int TILE_SHIFT   = 5,
    parameter int SCR_TILES_X  = 20,
    parameter int SCR_TILES_Y  = 15,
    parameter int LIST_DEPTH   = 256
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              frame_start,
    input  logic                              tri_valid,
    output logic                              tri_ready,
    input  logic signed [COORD_W-1:0]         tri_v0x,
    input  logic signed [COORD_W-1:0]         tri_v0y,
    input  logic signed [COORD_W-1:0]         tri_v1x,
    input  logic signed [COORD_W-1:0]         tri_v1y,
    input  logic signed [COORD_W-1:0]         tri_v2x,
    input  logic signed [COORD_W-1:0]         tri_v2y,
    input  logic [PRIM_W-1:0]                 tri_prim,
    output logic                              bin_valid,
    input  logic                              bin_ready,
    output logic [$clog2(SCR_TILES_X)-1:0]    bin_tx,
    output logic [$clog2(SCR_TILES_Y)-1:0]    bin_ty,
    output logic [PRIM_W-1:0]                 bin_prim,
    output logic                              flush_req,
    input  logic                              flush_done
);

    localparam int TX_W = $clog2(SCR_TILES_X);
    localparam int TY_W = $clog2(SCR_TILES_Y);

    logic            keep, single, full, ins;
    logic [TX_W-1:0] tx_lo, tx_hi;
    logic [TY_W-1:0] ty_lo, ty_hi;

    tbin_setup #(
        .COORD_W    (COORD_W),
        .TILE_SHIFT (TILE_SHIFT),
        .SCR_TX     (SCR_TILES_X),
        .SCR_TY     (SCR_TILES_Y)
    ) setup_i (
        .v0x    (tri_v0x),
        .v0y    (tri_v0y),
        .v1x    (tri_v1x),
        .v1y    (tri_v1y),
        .v2x    (tri_v2x),
        .v2y    (tri_v2y),
        .keep   (keep),
        .single (single),
        .tx_lo  (tx_lo),
        .tx_hi  (tx_hi),
        .ty_lo  (ty_lo),
        .ty_hi  (ty_hi)
    );

    tbin_capacity #(
        .LIST_DEPTH (LIST_DEPTH)
    ) cap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ins),
        .clr   (frame_start || flush_done),
        .full  (full)
    );

    tbin_walker #(
        .TX_W   (TX_W),
        .TY_W   (TY_W),
        .PRIM_W (PRIM_W)
    ) walk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tri_valid  (tri_valid),
        .tri_ready  (tri_ready),
        .tri_prim   (tri_prim),
        .keep       (keep),
        .single     (single),
        .tx_lo      (tx_lo),
        .tx_hi      (tx_hi),
        .ty_lo      (ty_lo),
        .ty_hi      (ty_hi),
        .full       (full),
        .ins        (ins),
        .flush_done (flush_done),
        .flush_req  (flush_req),
        .bin_valid  (bin_valid),
        .bin_ready  (bin_ready),
        .bin_tx     (bin_tx),
        .bin_ty     (bin_ty),
        .bin_prim   (bin_prim)
    );

endmodule

// File: tb/tri_tile_binner_tb_top.sv
module tri_tile_binner_tb_top;

    localparam int DEPTH = 16;
    localparam int XPIX  = 640;
    localparam int YPIX  = 480;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic tri_valid = 1'b0;
    logic tri_ready;
    logic signed [13:0] v0x = '0, v0y = '0, v1x = '0, v1y = '0, v2x = '0, v2y = '0;
    logic [15:0] prim = '0;
    logic bin_valid;
    logic bin_ready = 1'b1;
    logic [4:0] bin_tx;
    logic [3:0] bin_ty;
    logic [15:0] bin_prim;
    logic flush_req;
    logic flush_done = 1'b0;

    always #5 clk = ~clk;

    tri_tile_binner #(.LIST_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .tri_valid(tri_valid), .tri_ready(tri_ready),
        .tri_v0x(v0x), .tri_v0y(v0y), .tri_v1x(v1x), .tri_v1y(v1y),
        .tri_v2x(v2x), .tri_v2y(v2y), .tri_prim(prim),
        .bin_valid(bin_valid), .bin_ready(bin_ready),
        .bin_tx(bin_tx), .bin_ty(bin_ty), .bin_prim(bin_prim),
        .flush_req(flush_req), .flush_done(flush_done)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_tx[$], exp_ty[$], exp_pr[$];
    int acc_cyc[$], hs_cyc[$];
    int list_cnt = 0;
    int flush_cnt = 0;
    int hs_total = 0;
    bit bp_on = 1'b0;
    bit prev_stall = 1'b0;
    bit prev_fr = 1'b0;
    logic [4:0] prev_tx;
    logic [3:0] prev_ty;
    logic [15:0] prev_pr;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Reference coverage: R2 winding, R3 rejection, R4 clamp, R5 row-major order
    function automatic void model_tri(input int x0, y0, x1, y1, x2, y2, pr);
        longint a;
        int mnx, mxx, mny, mxy;
        a = longint'(x1 - x0) * (y2 - y0) - longint'(x2 - x0) * (y1 - y0);
        if (a <= 0) return;
        mnx = x0 < x1 ? x0 : x1; mnx = x2 < mnx ? x2 : mnx;
        mxx = x0 > x1 ? x0 : x1; mxx = x2 > mxx ? x2 : mxx;
        mny = y0 < y1 ? y0 : y1; mny = y2 < mny ? y2 : mny;
        mxy = y0 > y1 ? y0 : y1; mxy = y2 > mxy ? y2 : mxy;
        if (mxx < 0 || mxy < 0 || mnx > XPIX - 1 || mny > YPIX - 1) return;
        if (mnx < 0) mnx = 0;
        if (mny < 0) mny = 0;
        if (mxx > XPIX - 1) mxx = XPIX - 1;
        if (mxy > YPIX - 1) mxy = YPIX - 1;
        for (int ty = mny >> 5; ty <= (mxy >> 5); ty++)
            for (int tx = mnx >> 5; tx <= (mxx >> 5); tx++) begin
                exp_tx.push_back(tx);
                exp_ty.push_back(ty);
                exp_pr.push_back(pr);
            end
    endfunction

    // Per-cycle monitor, sampled away from the clock edge
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (prev_stall) begin
                // R8
                check(bin_valid && bin_tx == prev_tx && bin_ty == prev_ty && bin_prim == prev_pr,
                      "R8 hold", {bin_tx, bin_ty}, {prev_tx, prev_ty});
            end
            if (tri_valid && tri_ready) begin
                model_tri(v0x, v0y, v1x, v1y, v2x, v2y, prim);
                acc_cyc.push_back(cyc);
            end
            if (bin_valid && bin_ready) begin
                if (exp_tx.size() == 0) begin
                    check(0, "R4 unexpected entry", {bin_tx, bin_ty}, -1);
                end else begin
                    check(bin_tx == exp_tx[0] && bin_ty == exp_ty[0] && bin_prim == exp_pr[0],
                          "R4/R5 entry", {bin_prim, 3'b0, bin_tx, bin_ty},
                          {exp_pr[0][15:0], 3'b0, exp_tx[0][4:0], exp_ty[0][3:0]});
                    void'(exp_tx.pop_front());
                    void'(exp_ty.pop_front());
                    void'(exp_pr.pop_front());
                end
                // R9
                check(list_cnt < DEPTH, "R9 capacity", list_cnt + 1, DEPTH);
                list_cnt++;
                hs_total++;
                hs_cyc.push_back(cyc);
            end
            if (flush_req && !prev_fr) begin
                // R9
                check(list_cnt == DEPTH, "R9 flush at capacity", list_cnt, DEPTH);
                flush_cnt++;
            end
            if (flush_req && tri_ready)
                check(0, "R12 ready during flush", 1, 0);
            if (flush_done || frame_start)
                list_cnt = 0;
            prev_stall = bin_valid && !bin_ready;
            prev_tx = bin_tx;
            prev_ty = bin_ty;
            prev_pr = bin_prim;
            prev_fr = flush_req;
        end
    end

    task automatic send(input int x0, y0, x1, y1, x2, y2, pr);
        v0x = 14'(x0); v0y = 14'(y0);
        v1x = 14'(x1); v1y = 14'(y1);
        v2x = 14'(x2); v2y = 14'(y2);
        prim = 16'(pr);
        tri_valid = 1'b1;
        #1;
        while (!tri_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        tri_valid = 1'b0;
    endtask

    task automatic wait_drain();
        while (exp_tx.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Downstream partial-render responder
    initial begin
        forever begin
            @(negedge clk);
            if (flush_req) begin
                repeat (2) @(negedge clk);
                flush_done = 1'b1;
                @(negedge clk);
                flush_done = 1'b0;
            end
        end
    end

    // Output stall generator
    initial begin
        int lf = 32'h1d3a;
        forever begin
            @(negedge clk);
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            bin_ready = bp_on ? lf[3] : 1'b1;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        int a0, h0, f0, hs0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1
        check(!bin_valid && !flush_req && tri_ready, "R1 reset", {bin_valid, flush_req, tri_ready}, 3'b001);
        @(negedge clk);

        // R6: three single-tile triangles back to back
        a0 = acc_cyc.size(); h0 = hs_cyc.size();
        send(100, 70, 110, 70, 100, 80, 1);
        send(200, 200, 220, 200, 200, 215, 2);
        send(5, 5, 30, 5, 5, 30, 3);
        wait_drain();
        for (int i = 1; i < 3; i++)
            check(acc_cyc[a0 + i] == acc_cyc[a0 + i - 1] + 1, "R6 back-to-back accept",
                  acc_cyc[a0 + i] - acc_cyc[a0 + i - 1], 1);
        for (int i = 0; i < 3; i++)
            check(hs_cyc[h0 + i] == acc_cyc[a0 + i] + 1, "R6 entry next cycle",
                  hs_cyc[h0 + i] - acc_cyc[a0 + i], 1);

        // R7 / R5: 3x2 tile triangle walked on consecutive clocks
        h0 = hs_cyc.size();
        send(40, 70, 100, 70, 40, 100, 4);
        wait_drain();
        check(hs_cyc.size() - h0 == 6, "R7 entry count", hs_cyc.size() - h0, 6);
        check(hs_cyc[h0 + 5] - hs_cyc[h0] == 5, "R7 one per clock", hs_cyc[h0 + 5] - hs_cyc[h0], 5);

        // R2: back-facing and collinear triangles give nothing
        hs0 = hs_total;
        send(40, 70, 40, 100, 100, 70, 5);
        send(10, 10, 50, 50, 90, 90, 6);
        repeat (5) @(negedge clk);
        check(hs_total == hs0, "R2 culled", hs_total - hs0, 0);

        // R3: wholly off-screen triangles give nothing
        send(-300, -300, -200, -300, -300, -200, 7);
        send(700, 10, 800, 10, 700, 90, 8);
        send(10, 500, 90, 500, 10, 560, 9);
        repeat (5) @(negedge clk);
        check(hs_total == hs0, "R3 off-screen", hs_total - hs0, 0);

        // R4: clamping at left/top and right/bottom edges
        send(-20, -20, 50, -20, -20, 50, 10);
        send(600, 440, 900, 440, 600, 700, 11);
        wait_drain();
        check(hs_total - hs0 == 8, "R4 clamped entries", hs_total - hs0, 8);

        // R8: random stalls during a walk
        bp_on = 1'b1;
        send(0, 0, 150, 0, 0, 90, 12);
        send(300, 300, 305, 300, 300, 305, 13);
        wait_drain();
        bp_on = 1'b0;
        repeat (3) @(negedge clk);

        // R9 / R10 / R11: capacity and flush
        pulse_frame();
        f0 = flush_cnt;
        send(0, 0, 127, 0, 0, 127, 14);       // 16 tiles, fills list exactly
        wait_drain();
        check(flush_cnt == f0, "R9 no flush at exact fill", flush_cnt - f0, 0);
        send(330, 330, 340, 330, 330, 340, 15); // single tile while full
        wait_drain();
        check(flush_cnt == f0 + 1, "R9 flush before single", flush_cnt - f0, 1);
        send(0, 0, 159, 0, 0, 127, 16);       // 20 tiles, flush mid-walk
        wait_drain();
        check(flush_cnt == f0 + 2, "R10 flush mid-walk", flush_cnt - f0, 2);
        pulse_frame();
        send(0, 0, 127, 0, 0, 127, 17);       // 16 more fit after clear
        wait_drain();
        check(flush_cnt == f0 + 2, "R11 frame clear", flush_cnt - f0, 2);

        // R10: nothing left over
        check(exp_tx.size() == 0, "R10 all entries delivered", exp_tx.size(), 0);
        check(!bin_valid && !flush_req, "R10 idle at end", {bin_valid, flush_req}, 0);
        finish_run();
    end

endmodule